// File: doc/BRIEF.md
# Byte-wide Nonvolatile RAM Device Model

This block is the device end of an asynchronous byte-wide nonvolatile memory, rebuilt as clock-sampled logic so that a bus controller on the same chip can be exercised against a faithful target. The pins are sampled on every rising clock edge. Active-low chip select, write strobe and output enable are decoded into read and write operations on a main byte array. A separate 64-byte signature region is reached when the high-voltage flag that sits on address line 9 is raised. The data bus is split into an input byte, an output byte and a drive enable, which together form the tristate bus at the pad.

A supply-good input gates everything. When it drops, the model floats the bus and ignores every pin. When it returns, the model stays silent for a programmable number of cycles before it accepts accesses again. Moving between the main array and the signature region also costs a programmable number of cycles, during which the bus floats and writes are dropped.

The control state machine has four states:
- `ST_OFF`: supply is bad.
- `ST_WAKE`: recovery countdown.
- `ST_RUN`: normal access.
- `ST_SWITCH`: region change countdown.

Its transitions are named as follows:
- any state to `ST_OFF` on supply loss;
- `ST_OFF` to `ST_WAKE` when supply is good (counter loaded with `WAKE_CYC-1`);
- `ST_WAKE` to `ST_RUN` when the counter reaches zero;
- `ST_RUN` to `ST_SWITCH` when the flag differs from the current region (counter loaded with `SWITCH_CYC-1`, target region latched);
- `ST_SWITCH` to `ST_RUN` when the counter reaches zero, adopting the target region.

Top module: `nvram_dev`

## Requirements
- R1: The main array holds 2**ARRAY_AW bytes, indexed by `addr[ARRAY_AW-1:0]`. Every byte reads FFh after reset.
- R2: A write is pending while `ce_n` and `we_n` are both sampled low. On the first sampled edge where either of them is high again, `dq_i` on that edge is stored at `addr` on that edge.
- R3: Sampling `ce_n`=0, `oe_n`=0 and `we_n`=1 in normal operation makes `dq_oe` 1 one cycle later, with the addressed byte on `dq_o`. In every other case `dq_oe` is 0 one cycle later. During reset `dq_oe` is 0.
- R4: Sampling `we_n`=0 while a read is in progress makes `dq_oe` 0 on the next cycle.
- R5: With `hv_flag`=1, accesses go to the signature region. Its 6-bit index is {addr[7], addr[6], addr[14], addr[13], addr[12], addr[0]}, most significant bit first. Main array contents are not touched.
- R6: Signature index 0 reads 34h and index 1 reads 40h. Writes to these two indices are discarded.
- R7: Signature indices 2 to 63 read FFh after reset and accept writes as in R2.
- R8: When `hv_flag` differs from the current region, `dq_oe` stays 0 for SWITCH_CYC+1 cycles. Writes are ignored for that time. After it, the new region answers.
- R9: One cycle after `pwr_ok` is sampled low, `dq_oe` is 0. While `pwr_ok` is low, write cycles change nothing, and stored bytes are kept.
- R10: After `pwr_ok` returns, or after reset is released, `dq_oe` stays 0 for WAKE_CYC+1 cycles, and then a held read is answered.
- R11: A read sampled on the same edge as a write commit to the same location returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply-good indication; low blocks all operation |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_flag | input | 1 | High-voltage flag on address line 9; selects the signature region |
| addr | input | 15 | Byte address |
| dq_i | input | 8 | Data from the bus into the device |
| dq_o | output | 8 | Data driven onto the bus |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Every output is registered, so a read sampled on one edge is due on the following cycle. A write commit lands on the edge where the strobe overlap ends, and it is visible to a read sampled on that same edge. The bench drives pins on falling edges, updates its behavioural model on rising edges, and compares `dq_oe` and, when driven, `dq_o` on the next falling edge, every cycle. The two waiting periods are checked by holding a read request and counting silent cycles: SWITCH_CYC+1 after a flag change and WAKE_CYC+1 after supply or reset returns.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAKE   = 2'd1,
        ST_RUN    = 2'd2,
        ST_SWITCH = 2'd3
    } nv_state_e;

    localparam int          DEV_ADDR_W = 15;
    localparam int          SIG_IDX_W  = 6;
    localparam int          SIG_DEPTH  = 1 << SIG_IDX_W;
    localparam logic [7:0]  SIG_MAKER  = 8'h34;
    localparam logic [7:0]  SIG_PART   = 8'h40;
    localparam logic [7:0]  ERASED     = 8'hFF;

    // Signature index: A7 A6 A14 A13 A12 A0, MSB first (R5)
    function automatic logic [SIG_IDX_W-1:0] sig_index(input logic [DEV_ADDR_W-1:0] a);
        return {a[7], a[6], a[14], a[13], a[12], a[0]};
    endfunction

endpackage

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int WAKE_CYC   = 2500,
    parameter int SWITCH_CYC = 18
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_ok,
    input  logic      hv_flag,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    output nv_state_e state,
    output logic      id_mode,
    output logic      wr_commit,
    output logic      rd_en
);

    localparam int LONGEST = (WAKE_CYC > SWITCH_CYC) ? WAKE_CYC : SWITCH_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD   = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] SWITCH_LOAD = CNT_W'(SWITCH_CYC - 1);

    nv_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mode_q, mode_d;
    logic             tgt_q, tgt_d;
    logic             wr_pend_q;
    logic             access_ok;
    logic             strobe_low;

    // next-state decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        if (!pwr_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_WAKE;
                    cnt_d   = WAKE_LOAD;
                end
                ST_WAKE: begin
                    if (cnt_q == '0) state_d = ST_RUN;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_RUN: begin
                    if (hv_flag != mode_q) begin
                        state_d = ST_SWITCH;
                        cnt_d   = SWITCH_LOAD;
                        tgt_d   = hv_flag;
                    end
                end
                ST_SWITCH: begin
                    if (cnt_q == '0) begin
                        state_d = ST_RUN;
                        mode_d  = tgt_q;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            cnt_q     <= '0;
            mode_q    <= 1'b0;
            tgt_q     <= 1'b0;
            wr_pend_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            mode_q    <= mode_d;
            tgt_q     <= tgt_d;
            wr_pend_q <= access_ok && strobe_low;
        end
    end

    // outputs
    always_comb begin
        access_ok  = pwr_ok && (state_q == ST_RUN) && (hv_flag == mode_q);
        strobe_low = !ce_n && !we_n;
        wr_commit  = access_ok && wr_pend_q && !strobe_low;
        rd_en      = access_ok && !ce_n && !oe_n && we_n;
        state      = state_q;
        id_mode    = mode_q;
    end

endmodule

// File: rtl/nvram_store.sv
module nvram_store
    import nvram_pkg::*;
#(
    parameter int ARRAY_AW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEV_ADDR_W-1:0] addr,
    input  logic [7:0]            din,
    input  logic                  id_mode,
    input  logic                  wr_commit,
    input  logic                  rd_en,
    output logic [7:0]            dq_o,
    output logic                  dq_oe
);

    localparam int DEPTH = 1 << ARRAY_AW;

    logic [7:0]           main_mem [DEPTH];
    logic [7:0]           sig_mem  [SIG_DEPTH];
    logic [SIG_IDX_W-1:0] sidx;
    logic [ARRAY_AW-1:0]  midx;
    logic                 sig_fixed;
    logic                 wr_lands;
    logic [7:0]           stored;
    logic [7:0]           rd_byte;
    logic                 unused_addr;

    assign sidx        = sig_index(addr);
    assign midx        = addr[ARRAY_AW-1:0];
    assign sig_fixed   = (sidx < SIG_IDX_W'(2));
    assign wr_lands    = wr_commit && !(id_mode && sig_fixed);
    assign unused_addr = &{1'b0, addr};

    always_comb begin
        if (!id_mode)                      stored = main_mem[midx];
        else if (sidx == SIG_IDX_W'(0))    stored = SIG_MAKER;
        else if (sidx == SIG_IDX_W'(1))    stored = SIG_PART;
        else                               stored = sig_mem[sidx];
        rd_byte = wr_lands ? din : stored;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)     main_mem[i] <= ERASED;
            for (int j = 0; j < SIG_DEPTH; j++) sig_mem[j]  <= ERASED;
            dq_o  <= 8'h00;
            dq_oe <= 1'b0;
        end else begin
            if (wr_lands) begin
                if (id_mode) sig_mem[sidx]  <= din;
                else         main_mem[midx] <= din;
            end
            dq_oe <= rd_en;
            dq_o  <= rd_en ? rd_byte : 8'h00;
        end
    end

endmodule

// File: rtl/nvram_dev.sv
module nvram_dev
    import nvram_pkg::*;
#(
    parameter int ARRAY_AW   = 11,
    parameter int WAKE_CYC   = 2500,
    parameter int SWITCH_CYC = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_ok,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic        hv_flag,
    input  logic [14:0] addr,
    input  logic [7:0]  dq_i,
    output logic [7:0]  dq_o,
    output logic        dq_oe
);

    nv_state_e state;
    logic      id_mode;
    logic      wr_commit;
    logic      rd_en;

    nvram_ctrl #(
        .WAKE_CYC  (WAKE_CYC),
        .SWITCH_CYC(SWITCH_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .hv_flag  (hv_flag),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .state    (state),
        .id_mode  (id_mode),
        .wr_commit(wr_commit),
        .rd_en    (rd_en)
    );

    nvram_store #(
        .ARRAY_AW(ARRAY_AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .din      (dq_i),
        .id_mode  (id_mode),
        .wr_commit(wr_commit),
        .rd_en    (rd_en),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/nvram_dev_chk.sv
module nvram_dev_chk
    import nvram_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pwr_ok,
    input logic      ce_n,
    input logic      we_n,
    input logic      oe_n,
    input logic      dq_oe,
    input nv_state_e state,
    input logic      id_mode,
    input logic      wr_commit
);

    a_r9_off_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !dq_oe);

    a_r3_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!ce_n && !oe_n && we_n));

    a_r4_strobe_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dq_oe);

    a_r10_quiet_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> !dq_oe);

    a_r8_region_moves_in_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_mode) |-> ($past(state) == ST_SWITCH));

    a_r2_commit_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (state == ST_RUN && pwr_ok));

endmodule

bind nvram_dev nvram_dev_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .state    (state),
    .id_mode  (id_mode),
    .wr_commit(wr_commit)
);

// File: tb/nvram_dev_test.sv
`timescale 1ns/1ps
module nvram_dev_test;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int WCYC  = 2500;
    localparam int SCYC  = 18;

    logic        clk = 1'b0;
    logic        rst_n, pwr_ok, ce_n, we_n, oe_n, hv_flag;
    logic [14:0] addr;
    logic [7:0]  dq_i;
    logic [7:0]  dq_o;
    logic        dq_oe;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 0;
    string cur_req = "R3";

    always #4 clk = ~clk;

    nvram_dev #(.ARRAY_AW(AW), .WAKE_CYC(WCYC), .SWITCH_CYC(SCYC)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .hv_flag(hv_flag), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [7:0] m_main [DEPTH];
    logic [7:0] m_sig  [64];
    int         m_phase;   // 0 off, 1 waking, 2 running, 3 switching
    int         m_wait;
    bit         m_region, m_target, m_pend, m_oe;
    logic [7:0] m_data;

    function automatic int sig_of(input logic [14:0] a);
        return a[7]*32 + a[6]*16 + a[14]*8 + a[13]*4 + a[12]*2 + a[0];
    endfunction

    function automatic logic [7:0] m_read(input logic [14:0] a);
        int k;
        if (!m_region) return m_main[a % DEPTH];
        k = sig_of(a);
        if (k == 0) return 8'h34;
        if (k == 1) return 8'h40;
        return m_sig[k];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_main[i] = 8'hFF;
            for (int i = 0; i < 64; i++)    m_sig[i]  = 8'hFF;
            m_phase = 0; m_wait = 0; m_region = 0; m_target = 0;
            m_pend = 0; m_oe = 0; m_data = 8'h00;
        end else begin
            bit ok, low;
            ok  = pwr_ok && (m_phase == 2) && (hv_flag == m_region);
            low = !ce_n && !we_n;
            if (ok && m_pend && !low) begin
                if (!m_region) m_main[addr % DEPTH] = dq_i;
                else if (sig_of(addr) >= 2) m_sig[sig_of(addr)] = dq_i;
            end
            m_oe = ok && !ce_n && !oe_n && we_n;
            if (m_oe) m_data = m_read(addr);
            m_pend = ok && low;
            if (!pwr_ok) m_phase = 0;
            else if (m_phase == 0) begin m_phase = 1; m_wait = WCYC; end
            else if (m_phase == 1) begin
                m_wait--; if (m_wait == 0) m_phase = 2;
            end else if (m_phase == 2) begin
                if (hv_flag != m_region) begin m_phase = 3; m_wait = SCYC; m_target = hv_flag; end
            end else begin
                m_wait--; if (m_wait == 0) begin m_phase = 2; m_region = m_target; end
            end
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (!finished) begin
            chk({cur_req, " bus enable vs model"}, {31'b0, dq_oe}, {31'b0, m_oe});
            if (m_oe) chk({cur_req, " bus data vs model"}, {24'b0, dq_o}, {24'b0, m_data});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit by_ce);
        @(negedge clk); addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk); if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk); idle();
    endtask

    task automatic rd(input logic [14:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        chk({tag, " read drives"}, {31'b0, dq_oe}, 32'd1);
        chk({tag, " read data"}, {24'b0, dq_o}, {24'b0, exp});
        idle();
    endtask

    // caller has set up a held read on this falling edge
    task automatic quiet_span(input int exp_zeros, input logic [7:0] exp, input string tag);
        int zeros = 0;
        for (int k = 0; k < 3 * WCYC; k++) begin
            @(negedge clk);
            if (dq_oe) break;
            zeros++;
        end
        chk({tag, " silent cycles"}, zeros, exp_zeros);
        chk({tag, " data after wait"}, {24'b0, dq_o}, {24'b0, exp});
        idle();
    endtask

    // ---------------- main sequence ----------------
    initial begin
        rst_n = 1'b0; pwr_ok = 1'b1; hv_flag = 1'b0; addr = '0; dq_i = '0;
        idle();
        repeat (3) @(negedge clk);
        chk("R3 reset state", {31'b0, dq_oe}, 32'd0);

        cur_req = "R10";
        rst_n = 1'b1; addr = 15'h0000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        quiet_span(WCYC + 1, 8'hFF, "R10 wake after reset, R1 erased");

        cur_req = "R1";
        rd(15'h0123, 8'hFF, "R1 erased byte");
        rd(15'h07FF, 8'hFF, "R1 top byte");

        cur_req = "R2";
        wr(15'h0123, 8'hA5, 1'b0);
        rd(15'h0123, 8'hA5, "R2 write ended by we_n");
        wr(15'h0200, 8'h3C, 1'b1);
        rd(15'h0200, 8'h3C, "R2 write ended by ce_n");

        cur_req = "R4";
        @(negedge clk); addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); chk("R3 read drives", {31'b0, dq_oe}, 32'd1);
        we_n = 1'b0; dq_i = 8'h5A;
        @(negedge clk); chk("R4 strobe floats bus", {31'b0, dq_oe}, 32'd0);
        we_n = 1'b1;
        @(negedge clk);
        chk("R11 same-edge read drives", {31'b0, dq_oe}, 32'd1);
        chk("R11 same-edge read data", {24'b0, dq_o}, 32'h5A);
        idle();
        rd(15'h0123, 8'h5A, "R2 overwrite");

        cur_req = "R8";
        @(negedge clk); hv_flag = 1'b1; addr = 15'h0000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        quiet_span(SCYC + 1, 8'h34, "R8 enter signature, R6 index 0");

        cur_req = "R6";
        rd(15'h0001, 8'h40, "R6 index 1");
        wr(15'h0000, 8'h00, 1'b0);
        rd(15'h0000, 8'h34, "R6 index 0 write discarded");
        wr(15'h0001, 8'h11, 1'b1);
        rd(15'h0001, 8'h40, "R6 index 1 write discarded");

        cur_req = "R7";
        rd(15'h2001, 8'hFF, "R7 user byte erased");
        wr(15'h2001, 8'h77, 1'b0);
        rd(15'h2001, 8'h77, "R7 user byte written");

        cur_req = "R5";
        wr(15'h2080, 8'h99, 1'b0);
        rd(15'h2FBE, 8'h99, "R5 index bits only");
        rd(15'h0080 | 15'h0040, 8'hFF, "R5 different index");

        cur_req = "R8";
        @(negedge clk); hv_flag = 1'b0; addr = 15'h0000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        quiet_span(SCYC + 1, 8'hFF, "R8 leave signature, R5 main untouched");
        rd(15'h0080, 8'hFF, "R5 main untouched by signature write");

        @(negedge clk); hv_flag = 1'b1; idle();
        wr(15'h3000, 8'h42, 1'b0);
        repeat (SCYC + 4) @(negedge clk);
        rd(15'h3000, 8'hFF, "R8 write during switch ignored");
        @(negedge clk); hv_flag = 1'b0;
        repeat (SCYC + 4) @(negedge clk);

        cur_req = "R9";
        @(negedge clk); addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); chk("R3 read before drop", {31'b0, dq_oe}, 32'd1);
        pwr_ok = 1'b0;
        @(negedge clk); chk("R9 supply loss floats", {31'b0, dq_oe}, 32'd0);
        idle();
        wr(15'h0123, 8'h00, 1'b0);
        wr(15'h0200, 8'hEE, 1'b1);
        @(negedge clk); chk("R9 still floating", {31'b0, dq_oe}, 32'd0);

        cur_req = "R10";
        pwr_ok = 1'b1; addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        quiet_span(WCYC + 1, 8'h5A, "R10 recovery, R9 contents kept");
        rd(15'h0200, 8'h3C, "R9 blocked write left byte");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog %s actual=hung expected=done", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule